// File: doc/BRIEF.md
# Interlace Address Counter with Page Chaining

This block keeps the memory address and the remaining word count of one channel's interlace (block transfer). A control word loads the low fields of both registers and turns the interlace on. A separate extended load supplies the high-order bits of both registers. Each advance strobe from the data path moves the address forward by one word and takes one off the count. The data path uses the zero-count flag to end the transfer.

A chain register lets a transfer continue on another memory page. Software writes a 6-bit chain word that holds a page number and an interrupt-enable bit, which arms a pending chain. When an advance carries the address onto the first word of a page while a chain is pending, the address jumps to the start of the chained page. The chain is then consumed, and a one-cycle interrupt pulse is raised if the chain word asked for one. Memory access itself is outside this block.

Top module: `ilace_addr_chain`

## Requirements
- R1: While rst_n is low (asynchronous), addr_o and wcount_o are 0, ilc_en_o is 0, chain_irq_o is 0, wc_zero_o is 1 and no chain is pending.
- R2: On a clock edge with ilc_load_i high, addr_o[13:0] takes ilc_word_i[13:0] and wcount_o[9:0] takes ilc_word_i[23:14]. The high bits of both registers keep their value, and ilc_en_o becomes 1.
- R3: On a clock edge with start_i high, addr_o, wcount_o and ilc_en_o are cleared. If ilc_load_i is also high, the load of R2 is applied on top of the cleared registers.
- R4: On a clock edge with ext_load_i high, and neither start_i nor ilc_load_i high, addr_o[15:14] takes ext_addr_hi_i and wcount_o[14:10] takes ext_wc_hi_i. The low fields keep their value.
- R5: An advance (advance_i high, ilc_en_o high, and no load or start in the same cycle) adds 1 to addr_o modulo 2^16 and subtracts 1 from wcount_o modulo 2^15, unless R8 applies.
- R6: advance_i while ilc_en_o is 0 leaves addr_o and wcount_o unchanged.
- R7: A clock edge with chain_load_i high stores chain_word_i. Bit 5 is the interrupt enable and bits 4:0 are the page number. The store marks a chain as pending.
- R8: If a chain is pending and the incremented address has bits 10:0 all zero, the advance loads addr_o with {page, 11'b0} and clears the pending chain. wcount_o still decrements.
- R9: chain_irq_o is high for exactly the one cycle after an advance that chained, and only if bit 5 of the stored chain word was 1.
- R10: A pending chain persists across advances that do not reach a page boundary. A boundary reached with no chain pending is a plain increment.
- R11: wc_zero_o is 1 exactly when wcount_o is 0, in the same cycle.
- R12: An advance that takes wcount_o from 1 to 0 clears ilc_en_o.
- R13: A load or start in the same cycle as advance_i takes priority, and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new interlace: clear address, count and enable |
| ilc_load_i | input | 1 | Load the interlace control word |
| ilc_word_i | input | 24 | Control word: count in 23:14, address in 13:0 |
| ext_load_i | input | 1 | Load the high-order bits |
| ext_addr_hi_i | input | 2 | Address bits 15:14 |
| ext_wc_hi_i | input | 5 | Count bits 14:10 |
| chain_load_i | input | 1 | Load the chain register |
| chain_word_i | input | 6 | Bit 5 interrupt enable, bits 4:0 next page |
| advance_i | input | 1 | One word was transferred |
| addr_o | output | 16 | Current memory address |
| wcount_o | output | 15 | Remaining word count |
| wc_zero_o | output | 1 | Word count is zero |
| ilc_en_o | output | 1 | Interlace enabled |
| chain_irq_o | output | 1 | One-cycle chain interrupt pulse |

## Verification
Every strobe (load, start, extended load, chain load, advance) takes effect at the first rising edge that samples it. The new address, count and enable are therefore visible one cycle after the strobe. The chain interrupt pulse appears in that same cycle and is gone one cycle later. wc_zero_o follows wcount_o with no added delay. The bench drives inputs at the falling edge and samples 1 ns after the rising edge that should update the outputs, so every check lands in the cycle where its result is due.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int ILC_WORD_W    = 24;
  localparam int ILC_ADDR_LO_W = 14;
  localparam int ILC_WC_LO_W   = 10;
  localparam int CHAIN_PAGE_W  = 5;
  localparam int CHAIN_WORD_W  = CHAIN_PAGE_W + 1;

  typedef struct packed {
    logic                    irq_en;
    logic [CHAIN_PAGE_W-1:0] page;
  } chain_cfg_t;
endpackage

// File: rtl/iac_chain_reg.sv
module iac_chain_reg
  import iac_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [CHAIN_WORD_W-1:0] word_i,
  input  logic                    take_i,
  output logic                    pending_o,
  output logic [CHAIN_PAGE_W-1:0] page_o,
  output logic                    irq_o
);
  chain_cfg_t cfg_q, cfg_d;
  logic       pend_q, pend_d;
  logic       irq_q, irq_d;

  always_comb begin
    cfg_d  = cfg_q;
    pend_d = pend_q;
    if (take_i) pend_d = 1'b0;
    if (load_i) begin
      cfg_d  = chain_cfg_t'(word_i);
      pend_d = 1'b1;
    end
    irq_d = take_i & cfg_q.irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign pending_o = pend_q;
  assign page_o    = cfg_q.page;
  assign irq_o     = irq_q;
endmodule

// File: rtl/iac_addr_path.sv
module iac_addr_path
  import iac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 11,
  localparam int HI_W  = ADDR_W - ILC_ADDR_LO_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     load_lo_i,
  input  logic [ILC_ADDR_LO_W-1:0] lo_i,
  input  logic                     load_hi_i,
  input  logic [HI_W-1:0]          hi_i,
  input  logic                     step_i,
  input  logic                     pending_i,
  input  logic [CHAIN_PAGE_W-1:0]  page_i,
  output logic                     take_o,
  output logic [ADDR_W-1:0]        addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d, base, inc, chained;
  logic              boundary;

  assign inc      = addr_q + ADDR_W'(1);
  assign boundary = (inc[OFF_W-1:0] == '0);
  assign take_o   = step_i & pending_i & boundary;

  always_comb begin
    chained = '0;
    chained[OFF_W +: CHAIN_PAGE_W] = page_i;
    base   = clear_i ? '0 : addr_q;
    addr_d = addr_q;
    if (load_lo_i)      addr_d = {base[ADDR_W-1:ILC_ADDR_LO_W], lo_i};
    else if (clear_i)   addr_d = '0;
    else if (load_hi_i) addr_d = {hi_i, addr_q[ILC_ADDR_LO_W-1:0]};
    else if (step_i)    addr_d = take_o ? chained : inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/iac_count_path.sv
module iac_count_path
  import iac_pkg::*;
#(
  parameter int WC_W  = 15,
  localparam int HI_W = WC_W - ILC_WC_LO_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   load_lo_i,
  input  logic [ILC_WC_LO_W-1:0] lo_i,
  input  logic                   load_hi_i,
  input  logic [HI_W-1:0]        hi_i,
  input  logic                   step_i,
  output logic [WC_W-1:0]        wc_o,
  output logic                   en_o
);
  logic [WC_W-1:0] wc_q, wc_d, base;
  logic            en_q, en_d;

  always_comb begin
    base = clear_i ? '0 : wc_q;
    wc_d = wc_q;
    en_d = en_q;
    if (load_lo_i) begin
      wc_d = {base[WC_W-1:ILC_WC_LO_W], lo_i};
      en_d = 1'b1;
    end else if (clear_i) begin
      wc_d = '0;
      en_d = 1'b0;
    end else if (load_hi_i) begin
      wc_d = {hi_i, wc_q[ILC_WC_LO_W-1:0]};
    end else if (step_i) begin
      wc_d = wc_q - WC_W'(1);
      if (wc_q == WC_W'(1)) en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q <= '0;
      en_q <= 1'b0;
    end else begin
      wc_q <= wc_d;
      en_q <= en_d;
    end
  end

  assign wc_o = wc_q;
  assign en_o = en_q;
endmodule

// File: rtl/ilace_addr_chain.sv
module ilace_addr_chain
  import iac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WC_W   = 15,
  parameter int OFF_W  = 11
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start_i,
  input  logic                                ilc_load_i,
  input  logic [ILC_WORD_W-1:0]               ilc_word_i,
  input  logic                                ext_load_i,
  input  logic [ADDR_W-ILC_ADDR_LO_W-1:0]     ext_addr_hi_i,
  input  logic [WC_W-ILC_WC_LO_W-1:0]         ext_wc_hi_i,
  input  logic                                chain_load_i,
  input  logic [CHAIN_WORD_W-1:0]             chain_word_i,
  input  logic                                advance_i,
  output logic [ADDR_W-1:0]                   addr_o,
  output logic [WC_W-1:0]                     wcount_o,
  output logic                                wc_zero_o,
  output logic                                ilc_en_o,
  output logic                                chain_irq_o
);
  logic                    step, take, pending;
  logic [CHAIN_PAGE_W-1:0] page;

  assign step = advance_i & ilc_en_o & ~start_i & ~ilc_load_i & ~ext_load_i;

  iac_chain_reg u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (chain_load_i),
    .word_i    (chain_word_i),
    .take_i    (take),
    .pending_o (pending),
    .page_o    (page),
    .irq_o     (chain_irq_o)
  );

  iac_addr_path #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_i),
    .load_lo_i (ilc_load_i),
    .lo_i      (ilc_word_i[ILC_ADDR_LO_W-1:0]),
    .load_hi_i (ext_load_i),
    .hi_i      (ext_addr_hi_i),
    .step_i    (step),
    .pending_i (pending),
    .page_i    (page),
    .take_o    (take),
    .addr_o    (addr_o)
  );

  iac_count_path #(.WC_W(WC_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_i),
    .load_lo_i (ilc_load_i),
    .lo_i      (ilc_word_i[ILC_WORD_W-1:ILC_ADDR_LO_W]),
    .load_hi_i (ext_load_i),
    .hi_i      (ext_wc_hi_i),
    .step_i    (step),
    .wc_o      (wcount_o),
    .en_o      (ilc_en_o)
  );

  assign wc_zero_o = (wcount_o == '0);
endmodule

// File: rtl/ilace_addr_chain_chk.sv
module ilace_addr_chain_chk
  import iac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WC_W   = 15,
  parameter int OFF_W  = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    ilc_load_i,
  input logic [ILC_WORD_W-1:0]   ilc_word_i,
  input logic                    ext_load_i,
  input logic                    advance_i,
  input logic [ADDR_W-1:0]       addr_o,
  input logic [WC_W-1:0]         wcount_o,
  input logic                    ilc_en_o,
  input logic                    chain_irq_o
);
  logic adv_ok, adv_idle;
  assign adv_ok   = advance_i & ilc_en_o & ~start_i & ~ilc_load_i & ~ext_load_i;
  assign adv_idle = advance_i & ~ilc_en_o & ~start_i & ~ilc_load_i & ~ext_load_i;

  assert_load_sets_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ilc_load_i |=> ilc_en_o && addr_o[ILC_ADDR_LO_W-1:0] == $past(ilc_word_i[ILC_ADDR_LO_W-1:0]));

  assert_ext_keeps_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_load_i && !ilc_load_i && !start_i) |=>
      addr_o[ILC_ADDR_LO_W-1:0] == $past(addr_o[ILC_ADDR_LO_W-1:0]) &&
      wcount_o[ILC_WC_LO_W-1:0] == $past(wcount_o[ILC_WC_LO_W-1:0]));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ok |=> wcount_o == $past(wcount_o) - WC_W'(1));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ok |=> (addr_o == $past(addr_o) + ADDR_W'(1)) || (addr_o[OFF_W-1:0] == '0));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_idle |=> $stable(addr_o) && $stable(wcount_o));

  assert_irq_at_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chain_irq_o |-> addr_o[OFF_W-1:0] == '0);

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_irq_o |=> !chain_irq_o);

  assert_last_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ok && wcount_o == WC_W'(1)) |=> !ilc_en_o);
endmodule

bind ilace_addr_chain ilace_addr_chain_chk #(.ADDR_W(ADDR_W), .WC_W(WC_W), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .ilc_load_i  (ilc_load_i),
  .ilc_word_i  (ilc_word_i),
  .ext_load_i  (ext_load_i),
  .advance_i   (advance_i),
  .addr_o      (addr_o),
  .wcount_o    (wcount_o),
  .ilc_en_o    (ilc_en_o),
  .chain_irq_o (chain_irq_o)
);

// File: tb/ilace_addr_chain_bench.sv
`timescale 1ns/1ps
module ilace_addr_chain_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, ilc_load_i, ext_load_i, chain_load_i, advance_i;
  logic [23:0] ilc_word_i;
  logic [1:0]  ext_addr_hi_i;
  logic [4:0]  ext_wc_hi_i;
  logic [5:0]  chain_word_i;
  logic [15:0] addr_o;
  logic [14:0] wcount_o;
  logic        wc_zero_o, ilc_en_o, chain_irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ilace_addr_chain u_ilace_addr_chain (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ilc_load_i(ilc_load_i),
    .ilc_word_i(ilc_word_i), .ext_load_i(ext_load_i), .ext_addr_hi_i(ext_addr_hi_i),
    .ext_wc_hi_i(ext_wc_hi_i), .chain_load_i(chain_load_i), .chain_word_i(chain_word_i),
    .advance_i(advance_i), .addr_o(addr_o), .wcount_o(wcount_o), .wc_zero_o(wc_zero_o),
    .ilc_en_o(ilc_en_o), .chain_irq_o(chain_irq_o)
  );

  typedef struct packed {
    logic        ld;
    logic [23:0] word;
    logic        ext;
    logic [1:0]  ahi;
    logic [4:0]  whi;
    logic        cld;
    logic [5:0]  cw;
    logic        adv;
    logic        st;
    logic [15:0] eaddr;
    logic [14:0] ewc;
    logic        een;
    logic        eirq;
  } vec_t;

  localparam int NV = 12;
  localparam logic [74:0] TBL [NV] = '{
    {1'b1, 24'h00C7FE, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b0, 1'b0, 16'h07FE, 15'd3, 1'b1, 1'b0},
    {1'b0, 24'h000000, 1'b0, 2'd0, 5'd0, 1'b1, 6'h25, 1'b0, 1'b0, 16'h07FE, 15'd3, 1'b1, 1'b0},
    {1'b0, 24'h000000, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b1, 1'b0, 16'h07FF, 15'd2, 1'b1, 1'b0},
    {1'b0, 24'h000000, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b1, 1'b0, 16'h2800, 15'd1, 1'b1, 1'b1},
    {1'b0, 24'h000000, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b1, 1'b0, 16'h2801, 15'd0, 1'b0, 1'b0},
    {1'b0, 24'h000000, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b1, 1'b0, 16'h2801, 15'd0, 1'b0, 1'b0},
    {1'b0, 24'h000000, 1'b1, 2'd2, 5'd1, 1'b0, 6'h00, 1'b0, 1'b0, 16'hA801, 15'h0400, 1'b0, 1'b0},
    {1'b1, 24'h007FFF, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b0, 1'b1, 16'h3FFF, 15'd1, 1'b1, 1'b0},
    {1'b0, 24'h000000, 1'b0, 2'd0, 5'd0, 1'b1, 6'h03, 1'b0, 1'b0, 16'h3FFF, 15'd1, 1'b1, 1'b0},
    {1'b0, 24'h000000, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b1, 1'b0, 16'h1800, 15'd0, 1'b0, 1'b0},
    {1'b1, 24'h008010, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b1, 1'b0, 16'h0010, 15'd2, 1'b1, 1'b0},
    {1'b0, 24'h000000, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b1, 1'b0, 16'h0011, 15'd1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    start_i = 0; ilc_load_i = 0; ext_load_i = 0; chain_load_i = 0; advance_i = 0;
    ilc_word_i = '0; ext_addr_hi_i = '0; ext_wc_hi_i = '0; chain_word_i = '0;
  endtask

  task automatic check_all(input string req, input logic [15:0] a, input logic [14:0] w,
                           input logic en, input logic irq);
    chk({req, " addr"}, 32'(addr_o), 32'(a));
    chk({req, " wcount"}, 32'(wcount_o), 32'(w));
    chk({req, " enable"}, 32'(ilc_en_o), 32'(en));
    chk({req, " irq"}, 32'(chain_irq_o), 32'(irq));
    chk("R11 zero flag", 32'(wc_zero_o), 32'(w == 15'd0));
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    ilc_load_i = v.ld; ilc_word_i = v.word; ext_load_i = v.ext; ext_addr_hi_i = v.ahi;
    ext_wc_hi_i = v.whi; chain_load_i = v.cld; chain_word_i = v.cw; advance_i = v.adv;
    start_i = v.st;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset", 16'h0, 15'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table: R2 load, R7 chain store, R10 pending held, R8/R9 chaining with irq,
    // R12 last word, R6 idle advance, R4 extended load, R3 start+load,
    // R8 chaining without irq, R13 load beats advance, R5 plain step.
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(TBL[i]);
      apply(v);
      check_all($sformatf("R2-R13 vector %0d", i), v.eaddr, v.ewc, v.een, v.eirq);
    end

    // R5 wrap of both registers
    apply(vec_t'({1'b1, 24'h003FFF, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b0, 1'b0, 33'h0}));
    check_all("R2 reload", 16'h3FFF, 15'h0, 1'b1, 1'b0);
    apply(vec_t'({1'b0, 24'h000000, 1'b1, 2'd3, 5'd0, 1'b0, 6'h00, 1'b0, 1'b0, 33'h0}));
    check_all("R4 high bits", 16'hFFFF, 15'h0, 1'b1, 1'b0);
    apply(vec_t'({1'b0, 24'h000000, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b1, 1'b0, 33'h0}));
    check_all("R5 wrap", 16'h0000, 15'h7FFF, 1'b1, 1'b0);

    // R10 boundary without a pending chain increments plainly
    apply(vec_t'({1'b1, 24'h0147FF, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b0, 1'b0, 33'h0}));
    check_all("R2 keep high", 16'h07FF, 15'h7C05, 1'b1, 1'b0);
    apply(vec_t'({1'b0, 24'h000000, 1'b0, 2'd0, 5'd0, 1'b0, 6'h00, 1'b1, 1'b0, 33'h0}));
    check_all("R10 no chain", 16'h0800, 15'h7C04, 1'b1, 1'b0);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_all("R1 async reset", 16'h0, 15'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule